// File: doc/BRIEF.md
# Direct-Mapped Second-Level Cache Tag Controller

This block keeps the tags and per-line state for an external direct-mapped write-back second-level cache. A CPU-side requester presents a line address with a read or write flag through a valid/ready handshake. The controller reads the stored tag from an external 8-bit-wide synchronous tag SRAM and reads the valid and dirty state from its own line-state array. It then reports a hit, or resolves a miss. A miss sequences a four-beat write-back burst of a dirty victim when one is present, then a four-beat fill burst, and then updates tag and state. One completion pulse per request carries the hit/miss result.

A strap input selects between a small and a wide geometry. The wide geometry doubles the line count and uses one more index bit and one fewer tag bit. The freed tag SRAM bit then holds each line's dirty flag, and the whole internal array holds valid flags. A sweep clears all valid state after reset and on request, holding a busy output while it runs. Line and bus sizes, index and tag widths are parameters. With the default parameters a line is 32 bytes carried in four 8-byte beats. Setting IDX_W to 13 gives the full 8192/16384-line geometry.

Top module: `l2_tag_ctrl`

## Requirements
- R1: The line address splits by mode. Small mode (mode_big=0): index = bits [IDX_W-1:0], tag = the upper TAG_W bits, and the tag SRAM is addressed with a leading 0. Wide mode: index = bits [IDX_W:0], tag = the upper TAG_W-1 bits. Defaults: 8/8 bits small, 9/7 bits wide.
- R2: After reset, and in the cycle after inv_start is seen while idle, busy stays high for exactly 2^IDX_W cycles (256 by default) and req_ready is low. Afterwards every line is invalid.
- R3: A read hit raises done with done_hit=1 in the second cycle after the accepting clock edge, with no burst and no tag SRAM write.
- R4: A miss on an invalid or clean line runs only a fill burst (burst_wr=0) on the request line. The tag SRAM then gets the new tag, the line becomes valid, and done pulses with done_hit=0. After a read fill the line is clean.
- R5: A miss on a valid dirty line first runs a write-back burst (burst_wr=1) on the victim line. The victim line is rebuilt from the stored tag and the index. The fill burst follows.
- R6: A write hit marks the line dirty with no burst. In small mode the tag SRAM is not written. In wide mode it is written once with the tag bits unchanged and the dirty bit set.
- R7: A write miss fills the line and leaves it dirty, so its later replacement writes it back.
- R8: Each burst is four beats numbered 0,1,2,3. burst_beat, burst_line and burst_wr hold while burst_rdy is low, and a beat completes on each cycle with burst_act and burst_rdy both high.
- R9: The tag SRAM word holds the whole 8-bit tag in small mode. In wide mode, bits [6:0] hold the tag and bit 7 holds the dirty flag.
- R10: In wide mode, lines whose indices differ only in the top index bit keep independent valid state.
- R11: inv_start wins over req_valid in the same idle cycle, and no request is accepted or completed while busy is high.
- R12: An invalidate sweep discards dirty lines without write-back: a later miss on such a line causes no write-back burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_big | input | 1 | Geometry strap: 1 selects the wide (doubled) geometry |
| inv_start | input | 1 | Start an invalidate sweep (taken when idle) |
| busy | output | 1 | Invalidate sweep in progress |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_line | input | IDX_W+TAG_W | Line address of the request |
| req_write | input | 1 | 1 for a write request, 0 for a read |
| done | output | 1 | One-cycle completion pulse |
| done_hit | output | 1 | Request hit (valid with done) |
| tag_addr | output | IDX_W+1 | Tag SRAM address |
| tag_we | output | 1 | Tag SRAM write enable |
| tag_wdata | output | TAG_W | Tag SRAM write word |
| tag_rdata | input | TAG_W | Tag SRAM read word, one cycle after the address |
| burst_act | output | 1 | A burst beat is being offered |
| burst_wr | output | 1 | 1 for write-back, 0 for fill |
| burst_line | output | IDX_W+TAG_W | Line address of the burst |
| burst_beat | output | log2(LINE_BYTES/BUS_BYTES) | Beat number within the burst |
| burst_rdy | input | 1 | Memory side takes the current beat |

## Verification
The lookup is driven with read and write requests that hit, that miss on an invalid line, that miss on a clean line and that miss on a dirty line. These cases separate the four outcomes: no traffic, fill only, write-back then fill, and the dirty marking a write leaves behind. Each pattern runs in both geometries, with indices that reach the extra top index bit, to show where the dirty flag lives and that upper and lower lines are independent. Bursts run with a free and with a stalling memory side to separate beat advance from beat hold. Invalidate sweeps are issued together with a competing request and over dirty lines, to tell priority and the silent dropping of dirty data apart from a normal miss.

// File: rtl/l2tc_pkg.sv
package l2tc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_CMP,
    ST_WB,
    ST_FILL,
    ST_UPD,
    ST_INV
  } l2tc_state_e;
endpackage

// File: rtl/l2tc_wrap_ctr.sv
module l2tc_wrap_ctr #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = en && (&cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (en) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/l2tc_state_array.sv
module l2tc_state_array #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             big,
  input  logic [IDX_W:0]   idx,
  output logic             valid_o,
  output logic             dirty_o,
  input  logic             set_valid,
  input  logic             dirty_we,
  input  logic             dirty_val,
  input  logic             clr,
  input  logic [IDX_W-1:0] clr_row
);
  localparam int ROWS = 1 << IDX_W;

  logic [IDX_W-1:0] row;
  logic             hi;
  logic [1:0]       we, wv, rd;

  assign row = idx[IDX_W-1:0];
  assign hi  = idx[IDX_W];

  // bank 0: valid of low lines; bank 1: dirty (small) or valid of high lines (wide)
  always_comb begin
    if (big) begin
      we = {set_valid && hi, set_valid && !hi};
      wv = 2'b11;
    end else begin
      we = {dirty_we, set_valid};
      wv = {dirty_val, 1'b1};
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [ROWS-1:0] bits;
    always_ff @(posedge clk) begin
      if (clr) bits[clr_row] <= 1'b0;
      else if (we[b]) bits[row] <= wv[b];
    end
    assign rd[b] = bits[row];
  end

  assign valid_o = big ? rd[hi] : rd[0];
  assign dirty_o = big ? 1'b0 : rd[1];
endmodule

// File: rtl/l2_tag_ctrl.sv
module l2_tag_ctrl
  import l2tc_pkg::*;
#(
  parameter int LINE_BYTES = 32,
  parameter int BUS_BYTES  = 8,
  parameter int IDX_W      = 8,
  parameter int TAG_W      = 8,
  localparam int BEAT_W    = $clog2(LINE_BYTES / BUS_BYTES),
  localparam int LA_W      = IDX_W + TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_big,
  input  logic              inv_start,
  output logic              busy,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LA_W-1:0]   req_line,
  input  logic              req_write,
  output logic              done,
  output logic              done_hit,
  output logic [IDX_W:0]    tag_addr,
  output logic              tag_we,
  output logic [TAG_W-1:0]  tag_wdata,
  input  logic [TAG_W-1:0]  tag_rdata,
  output logic              burst_act,
  output logic              burst_wr,
  output logic [LA_W-1:0]   burst_line,
  output logic [BEAT_W-1:0] burst_beat,
  input  logic              burst_rdy
);
  // ---------------- address arithmetic ----------------
  function automatic logic [IDX_W:0] f_index(input logic [LA_W-1:0] l, input logic big);
    return big ? l[IDX_W:0] : {1'b0, l[IDX_W-1:0]};
  endfunction

  function automatic logic [TAG_W-1:0] f_tag(input logic [LA_W-1:0] l, input logic big);
    return big ? {1'b0, l[LA_W-1:IDX_W+1]} : l[LA_W-1:IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] f_word(input logic [TAG_W-1:0] t, input logic dirty,
                                              input logic big);
    return big ? {dirty, t[TAG_W-2:0]} : t;
  endfunction

  function automatic logic f_match(input logic [TAG_W-1:0] w, input logic [TAG_W-1:0] t,
                                   input logic big);
    return big ? (w[TAG_W-2:0] == t[TAG_W-2:0]) : (w == t);
  endfunction

  function automatic logic [LA_W-1:0] f_victim(input logic [TAG_W-1:0] w,
                                               input logic [IDX_W:0] ix, input logic big);
    return big ? {w[TAG_W-2:0], ix} : {w, ix[IDX_W-1:0]};
  endfunction

  // ---------------- state ----------------
  l2tc_state_e      st;
  logic [LA_W-1:0]  line_q, vict_q;
  logic             wr_q;

  logic [IDX_W:0]   idx_q;
  logic [TAG_W-1:0] tag_q;
  logic             sa_valid, sa_dirty, line_dirty;
  logic             in_cmp, in_inv;
  logic             beat_fire, beat_last;
  logic [IDX_W-1:0] sweep_row;
  logic             sweep_end;

  // named internal events
  logic ev_hit, ev_miss, ev_victim, ev_dirty_set, ev_wb_done, ev_fill_done, ev_update;

  assign idx_q      = f_index(line_q, mode_big);
  assign tag_q      = f_tag(line_q, mode_big);
  assign in_cmp     = (st == ST_CMP);
  assign in_inv     = (st == ST_INV);
  assign line_dirty = mode_big ? tag_rdata[TAG_W-1] : sa_dirty;

  assign ev_hit       = in_cmp && sa_valid && f_match(tag_rdata, tag_q, mode_big);
  assign ev_miss      = in_cmp && !ev_hit;
  assign ev_victim    = ev_miss && sa_valid && line_dirty;
  assign ev_dirty_set = ev_hit && wr_q;
  assign ev_update    = (st == ST_UPD);
  assign ev_wb_done   = (st == ST_WB) && beat_last;
  assign ev_fill_done = (st == ST_FILL) && beat_last;

  // ---------------- sub-blocks ----------------
  l2tc_state_array #(.IDX_W(IDX_W)) u_state (
    .clk       (clk),
    .big       (mode_big),
    .idx       (idx_q),
    .valid_o   (sa_valid),
    .dirty_o   (sa_dirty),
    .set_valid (ev_update),
    .dirty_we  (ev_update || ev_dirty_set),
    .dirty_val (ev_update ? wr_q : 1'b1),
    .clr       (in_inv),
    .clr_row   (sweep_row)
  );

  l2tc_wrap_ctr #(.W(BEAT_W)) u_beat (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (beat_fire),
    .cnt   (burst_beat),
    .wrap  (beat_last)
  );

  l2tc_wrap_ctr #(.W(IDX_W)) u_sweep (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (in_inv),
    .cnt   (sweep_row),
    .wrap  (sweep_end)
  );

  // ---------------- outputs ----------------
  assign busy       = in_inv;
  assign req_ready  = (st == ST_IDLE) && !inv_start;
  assign done       = ev_hit || ev_update;
  assign done_hit   = ev_hit;
  assign tag_addr   = idx_q;
  assign tag_we     = ev_update || (ev_dirty_set && mode_big);
  assign tag_wdata  = f_word(tag_q, ev_update ? wr_q : 1'b1, mode_big);
  assign burst_act  = (st == ST_WB) || (st == ST_FILL);
  assign burst_wr   = (st == ST_WB);
  assign burst_line = (st == ST_WB) ? vict_q : line_q;
  assign beat_fire  = burst_act && burst_rdy;

  // ---------------- sequencing ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_INV;
      line_q <= '0;
      vict_q <= '0;
      wr_q   <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (inv_start) st <= ST_INV;
          else if (req_valid) begin
            line_q <= req_line;
            wr_q   <= req_write;
            st     <= ST_LOOK;
          end
        end
        ST_LOOK: st <= ST_CMP;
        ST_CMP: begin
          if (ev_hit) st <= ST_IDLE;
          else if (ev_victim) begin
            vict_q <= f_victim(tag_rdata, idx_q, mode_big);
            st     <= ST_WB;
          end else st <= ST_FILL;
        end
        ST_WB:   if (ev_wb_done) st <= ST_FILL;
        ST_FILL: if (ev_fill_done) st <= ST_UPD;
        ST_UPD:  st <= ST_IDLE;
        ST_INV:  if (sweep_end) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/l2tc_chk.sv
module l2tc_chk #(
  parameter int LA_W   = 16,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_big,
  input logic              busy,
  input logic              req_ready,
  input logic              done,
  input logic              done_hit,
  input logic              tag_we,
  input logic              burst_act,
  input logic              burst_wr,
  input logic              burst_rdy,
  input logic [LA_W-1:0]   burst_line,
  input logic [BEAT_W-1:0] burst_beat,
  input logic              ev_hit,
  input logic              ev_miss,
  input logic              ev_wb_done
);
  a_r11_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready && !done);

  a_r8_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    burst_act && !burst_rdy |=> burst_act && $stable(burst_beat) && $stable(burst_line)
                                && $stable(burst_wr));

  a_r8_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
    burst_act && burst_rdy && (burst_beat != '1) |=>
      burst_act && (burst_beat == $past(burst_beat) + 1'b1));

  a_r5_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wb_done |=> burst_act && !burst_wr && (burst_beat == '0));

  a_r3_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_hit |=> !burst_act && !done);

  a_r6_small_no_tag_write: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit && !mode_big |-> !tag_we);

  a_r4_miss_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |-> !done && !burst_act);
endmodule

bind l2_tag_ctrl l2tc_chk #(.LA_W(LA_W), .BEAT_W(BEAT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_big   (mode_big),
  .busy       (busy),
  .req_ready  (req_ready),
  .done       (done),
  .done_hit   (done_hit),
  .tag_we     (tag_we),
  .burst_act  (burst_act),
  .burst_wr   (burst_wr),
  .burst_rdy  (burst_rdy),
  .burst_line (burst_line),
  .burst_beat (burst_beat),
  .ev_hit     (ev_hit),
  .ev_miss    (ev_miss),
  .ev_wb_done (ev_wb_done)
);

// File: tb/test_l2_tag_ctrl.sv
`timescale 1ns/1ps
module test_l2_tag_ctrl;
  localparam int IW = 8;
  localparam int TW = 8;
  localparam int LW = IW + TW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_big = 1'b0;
  logic          inv_start = 1'b0;
  logic          busy;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [LW-1:0] req_line = '0;
  logic          req_write = 1'b0;
  logic          done, done_hit;
  logic [IW:0]   tag_addr;
  logic          tag_we;
  logic [TW-1:0] tag_wdata, tag_rdata;
  logic          burst_act, burst_wr;
  logic [LW-1:0] burst_line;
  logic [1:0]    burst_beat;
  logic          burst_rdy = 1'b1;

  int total = 0, bad = 0, cyc = 0, stall = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  l2_tag_ctrl i_l2_tag_ctrl (.*);

  // behavioural tag SRAM, one-cycle read latency
  logic [TW-1:0] tag_mem [0:(2<<IW)-1];
  initial for (int i = 0; i < (2 << IW); i++) tag_mem[i] = '0;
  always @(posedge clk) begin
    if (tag_we) tag_mem[tag_addr] <= tag_wdata;
    tag_rdata <= tag_mem[tag_addr];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] mk(input int tag, input int idx);
    if (mode_big) return LW'((tag << (IW + 1)) | idx);
    return LW'((tag << IW) | idx);
  endfunction

  // results of the last access
  bit r_hit; int r_lat, r_wb, r_fill, r_twe; bit r_seq_ok;
  logic [LW-1:0] r_wb_line;

  task automatic access(input logic [LW-1:0] l, input bit w);
    int n;
    r_wb = 0; r_fill = 0; r_twe = 0; r_seq_ok = 1; r_hit = 0; r_wb_line = '0;
    @(negedge clk);
    req_valid = 1; req_line = l; req_write = w;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    n = 1;
    while (!done && n < 200) begin
      @(negedge clk);
      n++; cyc++;
      burst_rdy = (stall == 0) ? 1'b1 : (cyc % 3 == 0);
      if (tag_we) r_twe++;
      if (burst_act && burst_rdy) begin
        if (burst_wr) begin
          if (r_fill != 0 || burst_beat != 2'(r_wb)) r_seq_ok = 0;
          r_wb_line = burst_line;
          r_wb++;
        end else begin
          if (burst_beat != 2'(r_fill) || burst_line != l) r_seq_ok = 0;
          r_fill++;
        end
      end
      if (done) r_hit = done_hit;
    end
    r_lat = n;
    burst_rdy = 1;
    @(negedge clk);
  endtask

  task automatic count_busy(input string req, input bit from_reset);
    int c = 0;
    bit saw_done = 0;
    if (!from_reset) begin
      chk(busy == 1, req, "busy after start", busy, 1);
      chk(req_ready == 0, "R11", "ready while busy", req_ready, 0);
    end
    while (busy && c < 5000) begin
      c++;
      if (done || req_ready) saw_done = 1;
      @(negedge clk);
    end
    chk(c == (1 << IW), req, "busy cycles", c, 1 << IW);
    chk(!saw_done, "R11", "activity while busy", saw_done, 0);
  endtask

  task automatic invalidate(input bit with_req);
    @(negedge clk);
    inv_start = 1; req_valid = with_req; req_line = mk(1, 1); req_write = 0;
    @(negedge clk);
    inv_start = 0; req_valid = 0;
    count_busy("R2", 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(busy == 1 && req_ready == 0, "R2", "reset state busy/ready", {busy, req_ready}, 2'b10);
    rst_n = 1;
    count_busy("R2", 1);
  endtask

  task automatic t_small_basic;
    logic [LW-1:0] a = mk(8'h12, 5);
    access(a, 0);
    chk(!r_hit && r_wb == 0 && r_fill == 4, "R4", "clean read miss fill only",
        {r_hit, 8'(r_wb), 8'(r_fill)}, 4);
    chk(r_seq_ok, "R8", "fill beats in order on request line", r_seq_ok, 1);
    chk(tag_mem[5] == 8'h12, "R1", "tag stored at small index", tag_mem[5], 8'h12);
    chk(tag_mem[256 + 5] == 0, "R9", "upper tag entry untouched in small mode", tag_mem[261], 0);
    access(a, 0);
    chk(r_hit && r_lat == 2 && r_fill == 0 && r_twe == 0, "R3", "read hit latency",
        r_lat, 2);
    access(a, 1);
    chk(r_hit && r_wb == 0 && r_fill == 0, "R6", "write hit no burst", r_wb + r_fill, 0);
    chk(r_twe == 0 && tag_mem[5] == 8'h12, "R6", "small write hit leaves tag SRAM", r_twe, 0);
  endtask

  task automatic t_small_evict;
    stall = 1;
    access(mk(8'h34, 5), 0);
    stall = 0;
    chk(!r_hit && r_wb == 4 && r_fill == 4, "R5", "dirty victim wb then fill",
        {8'(r_wb), 8'(r_fill)}, 16'h0404);
    chk(r_wb_line == mk(8'h12, 5), "R5", "victim line rebuilt", r_wb_line, mk(8'h12, 5));
    chk(r_seq_ok, "R8", "beats ordered and held under stalls", r_seq_ok, 1);
    access(mk(8'h12, 5), 0);
    chk(r_wb == 0 && r_fill == 4, "R4", "clean line replaced without wb", r_wb, 0);
  endtask

  task automatic t_write_miss;
    access(mk(8'h55, 9), 1);
    chk(!r_hit && r_wb == 0 && r_fill == 4, "R7", "write miss fills", r_fill, 4);
    access(mk(8'h56, 9), 0);
    chk(r_wb == 4 && r_wb_line == mk(8'h55, 9), "R7", "write-miss line written back",
        r_wb_line, mk(8'h55, 9));
  endtask

  task automatic t_inv_drop;
    access(mk(8'h56, 9), 1);
    chk(r_hit, "R6", "write hit before sweep", r_hit, 1);
    invalidate(1);
    access(mk(8'h56, 9), 0);
    chk(!r_hit, "R2", "line invalid after sweep", r_hit, 0);
    chk(r_wb == 0, "R12", "dirty line dropped by sweep", r_wb, 0);
    chk(r_fill == 4, "R11", "precedent request was not taken", r_fill, 4);
  endtask

  task automatic t_wide;
    mode_big = 1;
    invalidate(0);
    access(mk(8'h11, 300), 0);
    chk(!r_hit && r_fill == 4, "R1", "wide index 300 miss fill", r_fill, 4);
    chk(tag_mem[300] == 8'h11, "R9", "wide tag word clean", tag_mem[300], 8'h11);
    access(mk(8'h22, 44), 0);
    access(mk(8'h11, 300), 0);
    chk(r_hit, "R10", "upper line still valid", r_hit, 1);
    access(mk(8'h22, 44), 0);
    chk(r_hit, "R10", "lower line still valid", r_hit, 1);
    access(mk(8'h11, 300), 1);
    chk(r_hit && r_wb == 0 && r_fill == 0 && r_twe == 1, "R6", "wide write hit one tag write",
        r_twe, 1);
    chk(tag_mem[300] == 8'h91, "R9", "dirty flag in bit 7", tag_mem[300], 8'h91);
    access(mk(8'h05, 300), 0);
    chk(r_wb == 4 && r_wb_line == mk(8'h11, 300), "R5", "wide victim rebuilt",
        r_wb_line, mk(8'h11, 300));
    chk(tag_mem[300] == 8'h05, "R4", "wide fill clears dirty flag", tag_mem[300], 8'h05);
    access(mk(8'h33, 44), 1);
    chk(!r_hit && r_wb == 0 && tag_mem[44] == 8'hB3, "R7", "wide write miss dirty word",
        tag_mem[44], 8'hB3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_small_basic();
    t_small_evict();
    t_write_miss();
    t_inv_drop();
    t_wide();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule